// File: doc/BRIEF.md
# Zone-Rate Bit-Cell Decoder

This block recovers a serial bit stream from a raw flux-reversal signal read off rotating media. It runs on a 16 MHz reference clock and makes a decoder-rate enable by dividing that clock by a divisor the 2-bit zone input selects. The divisor is 13, 14, 15 or 16, which gives roughly 307.7, 285.7, 266.7 and 250 kbit/s. At 300 rpm the slowest zone holds 50000 cells per revolution. Each bit cell spans four decoder ticks.

The flux input is asynchronous. It passes through a two-stage synchroniser, and its rising edge is detected on the reference clock. A detected reversal marks the current cell as a one and restarts both the divider and the cell phase, so the cell grid stays locked to the media. At the close of each cell the block presents the decoded bit on `dec_bit` together with a one-cycle `bit_strobe`. A cell with no reversal decodes as zero. Sync detection and byte assembly belong to downstream logic.

Top module: `zone_bit_decoder`

## Requirements
- R1: The zone input selects the reference divisor: 2'b00 divides by 13, 2'b01 by 14, 2'b10 by 15 and 2'b11 by 16.
- R2: With no flux activity, a `bit_strobe` pulse occurs once every 4×divisor reference cycles, so one cell lasts four decoder ticks.
- R3: A cell that contains a flux reversal closes with `dec_bit` = 1. A cell without one closes with `dec_bit` = 0.
- R4: Only a rising edge of `flux_in` counts as a reversal, and a level held high counts once. A reversal first sampled high at reference edge k is reported by a strobe carrying 1 at edge k+2+4×divisor, when no other reversal intervenes.
- R5: A reversal that arrives partway through a cell restarts the divider and the cell phase. The interrupted cell produces no strobe, and the next strobe comes 4×divisor cycles after the reversal is registered and carries 1.
- R6: When a reversal is registered in the same cycle that a cell closes, the closing cell is still emitted with its own value, and a new cell marked as one begins.
- R7: A change of the zone input takes effect at the next divider reload. The countdown already under way finishes with the old divisor.
- R8: `bit_strobe` is high for exactly one reference cycle per cell. `dec_bit` holds its value between strobes.
- R9: While `rst_n` is low, `bit_strobe` and `dec_bit` are 0. A reversal still pending when reset is applied is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zone | input | 2 | Density zone select (00 = fastest, 11 = slowest) |
| flux_in | input | 1 | Asynchronous flux-reversal input, rising edge active |
| dec_bit | output | 1 | Value of the most recently closed cell |
| bit_strobe | output | 1 | One-cycle pulse at the close of each cell |

## Verification
The embedded assertions watch the local invariants on every cycle. Each detected edge is a single-cycle pulse. A reversal leaves the phase at zero with the cell marked as one, and the divider never ticks in the cycle after a restart. The strobe lasts one cycle, and the decoded bit moves only together with the strobe. Absolute timing has to come from the bench's scenarios: the 4×divisor cell length in each zone, the latency through the synchroniser, the suppression of an interrupted cell, the emission of a cell that closes as a reversal lands, the delayed effect of a zone switch, and the loss of a pending one across reset.

// File: rtl/zbd_pkg.sv
package zbd_pkg;

    // Smallest divisor of the reference clock (zone code 0).
    localparam int unsigned REF_DIV_BASE   = 13;
    // Width of the zone select; each code step adds one to the divisor.
    localparam int unsigned ZONE_BITS      = 2;
    // Decoder ticks making up one bit cell.
    localparam int unsigned TICKS_PER_CELL = 4;
    // Synchroniser depth for the asynchronous flux input.
    localparam int unsigned SYNC_DEPTH     = 2;

endpackage

// File: rtl/zbd_flux_sync.sv
module zbd_flux_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flux_i,
    output logic rise_o
);

    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    // Shift chain built stage by stage; stage 0 samples the pin.
    logic [STAGES-1:0] chain_next;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign chain_next[g] = flux_i;
            end else begin : g_rest
                assign chain_next[g] = s_q.chain[g-1];
            end
        end
    endgenerate

    always_comb begin
        s_d       = s_q;
        s_d.chain = chain_next;
        s_d.last  = s_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.chain[TOP] & ~s_q.last;

    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);  // R4

endmodule

// File: rtl/zbd_rate_div.sv
module zbd_rate_div #(
    parameter int unsigned ZONE_W   = 2,
    parameter int unsigned DIV_BASE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ZONE_W-1:0] zone_i,
    input  logic              restart_i,
    output logic              tick_o
);

    localparam int unsigned DIV_MAX = DIV_BASE + (1 << ZONE_W) - 1;
    localparam int unsigned CNT_W   = $clog2(DIV_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t d_d, d_q;
    logic [CNT_W-1:0] reload;

    // Terminal count for the zone in force at the moment of reload.
    assign reload = CNT_W'(DIV_BASE - 1) + CNT_W'(zone_i);
    assign tick_o = (d_q.cnt == '0);

    always_comb begin
        d_d = d_q;
        if (restart_i || tick_o) begin
            d_d.cnt = reload;
        end else begin
            d_d.cnt = d_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o);  // R5

    AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (d_q.cnt >= CNT_W'(DIV_BASE - 1)));  // R1

endmodule

// File: rtl/zbd_cell_track.sv
module zbd_cell_track #(
    parameter int unsigned CELL_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rise_i,
    output logic bit_o,
    output logic strb_o
);

    localparam int unsigned PH_W = (CELL_TICKS > 1) ? $clog2(CELL_TICKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELL_TICKS - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            seen;
        logic            strb;
        logic            bitv;
    } cell_t;

    cell_t c_d, c_q;
    logic  closing;

    assign closing = tick_i && (c_q.phase == PH_LAST);

    always_comb begin
        c_d      = c_q;
        c_d.strb = 1'b0;
        // A cell that closes this cycle is always reported, even if a
        // reversal lands at the same time.
        if (closing) begin
            c_d.strb = 1'b1;
            c_d.bitv = c_q.seen;
        end
        if (rise_i) begin
            c_d.phase = '0;
            c_d.seen  = 1'b1;
        end else if (tick_i) begin
            if (closing) begin
                c_d.phase = '0;
                c_d.seen  = 1'b0;
            end else begin
                c_d.phase = c_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign bit_o  = c_q.bitv;
    assign strb_o = c_q.strb;

    AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> (c_q.phase == '0 && c_q.seen));  // R5

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.strb |=> !c_q.strb);  // R8

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.strb |-> $stable(c_q.bitv));  // R8

endmodule

// File: rtl/zone_bit_decoder.sv
module zone_bit_decoder
    import zbd_pkg::*;
#(
    parameter int unsigned DIV_BASE   = REF_DIV_BASE,
    parameter int unsigned ZONE_W     = ZONE_BITS,
    parameter int unsigned CELL_TICKS = TICKS_PER_CELL,
    parameter int unsigned SYNC_STG   = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ZONE_W-1:0] zone,
    input  logic              flux_in,
    output logic              dec_bit,
    output logic              bit_strobe
);

    logic flux_rise;
    logic dec_tick;

    zbd_flux_sync #(
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .flux_i (flux_in),
        .rise_o (flux_rise)
    );

    zbd_rate_div #(
        .ZONE_W   (ZONE_W),
        .DIV_BASE (DIV_BASE)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .zone_i    (zone),
        .restart_i (flux_rise),
        .tick_o    (dec_tick)
    );

    zbd_cell_track #(
        .CELL_TICKS (CELL_TICKS)
    ) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (dec_tick),
        .rise_i (flux_rise),
        .bit_o  (dec_bit),
        .strb_o (bit_strobe)
    );

endmodule

// File: tb/test_zone_bit_decoder.sv
module test_zone_bit_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] zone = 2'b00;
    logic       flux = 1'b0;
    logic       dec_bit;
    logic       bit_strobe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic last_bit = 1'b0;

    always #2.5 clk = ~clk;

    zone_bit_decoder i_zone_bit_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .zone       (zone),
        .flux_in    (flux),
        .dec_bit    (dec_bit),
        .bit_strobe (bit_strobe)
    );

    // Vector table: {zone code, number of zero cells after the one}.
    localparam logic [3:0] VECS [0:3] = '{4'b00_10, 4'b01_01, 4'b10_00, 4'b11_10};

    function automatic int div_of(input logic [1:0] z);
        return 13 + int'(z);  // R1 mapping
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Raises flux for two cycles, then watches len cycles. Cycle c counts
    // reference edges from the first edge that samples the raised input.
    task automatic drive_window(input logic [1:0] z, input int len, input int p2,
                                input int zc, input logic [1:0] zn,
                                input int s1, input int b1, input int s2, input int b2,
                                input int s3, input int b3, input string req);
        @(negedge clk);
        zone = z;
        flux = 1'b1;
        for (int c = 1; c <= len; c++) begin
            bit hit;
            logic expb;
            @(posedge clk);
            @(negedge clk);
            hit  = (c == s1) || (c == s2) || (c == s3);
            expb = (c == s1) ? b1[0] : (c == s2) ? b2[0] : b3[0];
            chk(bit_strobe === hit, req, $sformatf("strobe at cycle %0d", c),
                int'(bit_strobe), int'(hit));
            if (hit) begin
                chk(dec_bit === expb, req, $sformatf("bit at cycle %0d", c),
                    int'(dec_bit), int'(expb));
                last_bit = expb;
            end else begin
                chk(dec_bit === last_bit, "R8", $sformatf("held bit at cycle %0d", c),
                    int'(dec_bit), int'(last_bit));
            end
            if (c == 2) flux = 1'b0;
            if (p2 != 0 && c == p2) flux = 1'b1;
            if (p2 != 0 && c == p2 + 2) flux = 1'b0;
            if (zc != 0 && c == zc) zone = zn;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int prev_s;
        int n_strb;
        // R9: outputs idle under reset.
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(bit_strobe === 1'b0, "R9", "strobe in reset", int'(bit_strobe), 0);
        chk(dec_bit === 1'b0, "R9", "bit in reset", int'(dec_bit), 0);
        rst_n = 1'b1;

        // R2 / R3: free-running zero cells in zone 00 every 52 cycles.
        prev_s = -1;
        n_strb = 0;
        for (int c = 1; c <= 170; c++) begin
            @(posedge clk);
            @(negedge clk);
            chk(dec_bit === 1'b0, "R3", "idle cell value", int'(dec_bit), 0);
            if (bit_strobe) begin
                if (prev_s >= 0)
                    chk((c - prev_s) == 52, "R2", "cell spacing", c - prev_s, 52);
                prev_s = c;
                n_strb++;
            end
        end
        chk(n_strb >= 3, "R2", "idle strobe count", n_strb, 3);
        while (bit_strobe !== 1'b1) begin
            @(posedge clk);
            @(negedge clk);
        end

        // Vector walk: R1, R3, R4 latency in every zone.
        for (int v = 0; v < 4; v++) begin
            logic [1:0] z;
            int d, n;
            int s [3];
            z = VECS[v][3:2];
            n = int'(VECS[v][1:0]);
            d = div_of(z);
            for (int m = 0; m < 3; m++) s[m] = (m <= n) ? 3 + 4 * d * (m + 1) : 0;
            drive_window(z, 3 + 4 * d * (n + 1), 0, 0, 2'b00,
                         s[0], 1, s[1], 0, s[2], 0, "R4");
        end

        // R5: second reversal mid-cell suppresses the cell ending at 55.
        drive_window(2'b00, 133, 26, 0, 2'b00, 81, 1, 133, 0, 0, 0, "R5");

        // R6: reversal registered exactly as the cell closes at 107.
        drive_window(2'b00, 159, 104, 0, 2'b00, 55, 1, 107, 0, 159, 1, "R6");

        // R7: zone switch to 11 after the strobe at 55 applies at next reload.
        drive_window(2'b00, 180, 0, 55, 2'b11, 55, 1, 116, 0, 180, 0, "R7");

        // R9: reset while a one is pending discards it.
        @(negedge clk);
        zone = 2'b00;
        flux = 1'b1;
        repeat (2) @(negedge clk);
        flux = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(bit_strobe === 1'b0, "R9", "strobe during reset", int'(bit_strobe), 0);
            chk(dec_bit === 1'b0, "R9", "bit during reset", int'(dec_bit), 0);
        end
        rst_n = 1'b1;
        for (int c = 1; c <= 120; c++) begin
            @(negedge clk);
            chk(dec_bit === 1'b0, "R9", "pending one lost", int'(dec_bit), 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule